// File: doc/BRIEF.md
# Audio Front-End Mode Sequencer

This block is the control sequencer that places an audio capture front end into one of its operating modes. A mode request arrives as a code with a one-cycle strobe. The block then walks a fixed sequence of single-clock steps. It first forces the whole front end into power-down. Next it sets the power and enable lines for the digital microphone interface, the ADC path, the voice-activity detector, the detector's interrupt mask and the ADC wake path. It then loads the stored channel gains and automatic-gain limits, checking each set for validity. At the end it powers the front end up again, but only when the new mode is an active one.

The mode codes are 0 = off, 1 = voice-detect, 2 = record to memory, 3 = serial audio (I2S) output and 4 = memory plus I2S. Codes 5 to 7 are unknown. The stored configuration is read on the port lines at the step that uses it, so it must be held stable while `busy` is high. A request that arrives while a sequence is running is held in a one-deep slot, where the latest request wins. It starts as soon as the running sequence ends.

States, in order: `ST_IDLE` moves to `ST_PWRDN` on a strobe or a held request. `ST_PWRDN` moves to `ST_DET_OFF` for voice-detect and to `ST_PATH` for every other mode. The voice-detect branch runs `ST_DET_OFF` → `ST_FLAG_CLR` → `ST_DET_ON` → `ST_DET_RST` → `ST_PATH`. All modes then run `ST_PATH` → `ST_GAIN` → `ST_AGC` → `ST_FINAL` → `ST_IDLE`.

Top module: `afe_mode_seq`

## Requirements
- R1: Every accepted request first drives `mod_pd` to 1 in the cycle after `busy` rises, before any enable line changes.
- R2: When the sequence ends, `mod_pd` is 0 for modes 1 to 4 and stays 1 for mode 0 and for codes 5 to 7.
- R3: For mode 1, the detector is disabled while `det_flag_clr` pulses, then enabled before `det_restart` pulses. Each pulse occurs exactly once. The sequence ends with `mic_pd`=0, `adc_pd`=1, `det_en`=1, `det_irq_mask`=0, `adc_wake_en`=1 and `det_rate` loaded from `cfg_det_rate`.
- R4: For modes 2, 3 and 4, the sequence ends with `mic_pd`=0, `adc_pd`=0, `det_en`=0, `det_irq_mask`=1, `adc_wake_en`=0 and `adc_rate` loaded from `cfg_adc_rate`.
- R5: For mode 0, the sequence ends with `mic_pd`=1, `adc_pd`=1, `det_en`=0, `det_irq_mask`=1 and `adc_wake_en`=0. Both rate outputs are unchanged.
- R6: Codes 5 to 7 give the mode-0 pattern, and in addition force both `adc_rate` and `det_rate` to 0, the lowest clock setting.
- R7: If either configured channel gain is above 43 (0x2B), `cfg_err` is set and `gain_l`, `gain_r` and `gain_couple` keep their previous values. A gain of exactly 43 is accepted.
- R8: With `cfg_couple`=1 the right gain follows the left gain. With `cfg_couple`=0 each channel takes its own value.
- R9: If `cfg_agc_min` is greater than `cfg_agc_max`, `cfg_err` is set and both limits keep their previous values. Equal limits are accepted.
- R10: `busy` is high for exactly 9 cycles for mode 1 and for exactly 5 cycles for every other code.
- R11: A strobe while `busy` is high is held. After one idle cycle, the held request runs as a full sequence.
- R12: After reset, `mod_pd`, `mic_pd`, `adc_pd` and `det_irq_mask` are 1. All other outputs are 0, and `busy` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_mode | input | 3 | Requested mode code |
| cfg_couple | input | 1 | 1: right gain follows left |
| cfg_gain_l | input | 6 | Stored left channel gain |
| cfg_gain_r | input | 6 | Stored right channel gain |
| cfg_agc_min | input | 5 | Stored automatic-gain lower limit |
| cfg_agc_max | input | 5 | Stored automatic-gain upper limit |
| cfg_adc_rate | input | 2 | Microphone clock selection for the ADC path |
| cfg_det_rate | input | 2 | Microphone clock selection for the detector |
| mod_pd | output | 1 | Whole front-end power-down |
| mic_pd | output | 1 | Microphone interface power-down |
| adc_pd | output | 1 | ADC path power-down |
| det_en | output | 1 | Voice detector enable |
| det_irq_mask | output | 1 | Detector interrupt mask (1 = masked) |
| det_flag_clr | output | 1 | One-cycle detect-flag clear pulse |
| det_restart | output | 1 | One-cycle detector restart pulse |
| adc_wake_en | output | 1 | ADC wake on detection |
| adc_rate | output | 2 | Applied ADC microphone clock selection |
| det_rate | output | 2 | Applied detector microphone clock selection |
| gain_l | output | 6 | Applied left gain |
| gain_r | output | 6 | Applied right gain |
| gain_couple | output | 1 | Applied coupling bit |
| agc_min | output | 5 | Applied automatic-gain lower limit |
| agc_max | output | 5 | Applied automatic-gain upper limit |
| busy | output | 1 | Sequence in progress |
| cfg_err | output | 1 | Last sequence rejected a configuration |

## Verification
Every mode code is requested, including unknown codes 6 and 7, so that the final enable patterns of the off, detect, record and unknown classes can be told apart. The detect class is also checked for the order of the flag clear and the restart against the detector enable. Gains of 43 and 44 and automatic-gain limits that are equal or inverted separate the accept path from the reject path, and also show that a rejection leaves the previous values in place. A coupled request with unequal gains shows whether the right channel follows the left. A second strobe issued during a detect sequence shows whether a held request is kept and then replayed as a complete sequence.

// File: rtl/afe_seq_pkg.sv
package afe_seq_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWRDN,
        ST_DET_OFF,
        ST_FLAG_CLR,
        ST_DET_ON,
        ST_DET_RST,
        ST_PATH,
        ST_GAIN,
        ST_AGC,
        ST_FINAL
    } seq_state_t;

    typedef enum logic [1:0] {
        CLS_OFF,
        CLS_DET,
        CLS_REC,
        CLS_BAD
    } mode_cls_t;

    function automatic mode_cls_t classify(input logic [MODE_W-1:0] m);
        mode_cls_t c;
        case (m)
            3'd0:             c = CLS_OFF;
            3'd1:             c = CLS_DET;
            3'd2, 3'd3, 3'd4: c = CLS_REC;
            default:          c = CLS_BAD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/afe_seq_fsm.sv
module afe_seq_fsm
    import afe_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [MODE_W-1:0]     req_mode,
    output seq_state_t            state,
    output logic [MODE_W-1:0]     cur_mode,
    output logic                  busy
);

    seq_state_t        nxt;
    logic              held_v;
    logic [MODE_W-1:0] held_mode;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (req_valid || held_v) nxt = ST_PWRDN;
            ST_PWRDN:    nxt = (classify(cur_mode) == CLS_DET) ? ST_DET_OFF : ST_PATH;
            ST_DET_OFF:  nxt = ST_FLAG_CLR;
            ST_FLAG_CLR: nxt = ST_DET_ON;
            ST_DET_ON:   nxt = ST_DET_RST;
            ST_DET_RST:  nxt = ST_PATH;
            ST_PATH:     nxt = ST_GAIN;
            ST_GAIN:     nxt = ST_AGC;
            ST_AGC:      nxt = ST_FINAL;
            ST_FINAL:    nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // Active mode and one-deep held request (latest wins)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_mode  <= '0;
            held_v    <= 1'b0;
            held_mode <= '0;
        end else if (state == ST_IDLE) begin
            held_v <= 1'b0;
            if (req_valid)   cur_mode <= req_mode;
            else if (held_v) cur_mode <= held_mode;
        end else if (req_valid) begin
            held_v    <= 1'b1;
            held_mode <= req_mode;
        end
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/afe_path_regs.sv
module afe_path_regs
    import afe_seq_pkg::*;
#(
    parameter int RATE_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  seq_state_t            state,
    input  logic [MODE_W-1:0]     cur_mode,
    input  logic [RATE_W-1:0]     cfg_adc_rate,
    input  logic [RATE_W-1:0]     cfg_det_rate,
    output logic                  mod_pd,
    output logic                  mic_pd,
    output logic                  adc_pd,
    output logic                  det_en,
    output logic                  det_irq_mask,
    output logic                  det_flag_clr,
    output logic                  det_restart,
    output logic                  adc_wake_en,
    output logic [RATE_W-1:0]     adc_rate,
    output logic [RATE_W-1:0]     det_rate
);

    localparam logic [RATE_W-1:0] RATE_LOW = '0;

    mode_cls_t cls;
    assign cls = classify(cur_mode);

    // Output process: one action per sequence step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_pd       <= 1'b1;
            mic_pd       <= 1'b1;
            adc_pd       <= 1'b1;
            det_en       <= 1'b0;
            det_irq_mask <= 1'b1;
            det_flag_clr <= 1'b0;
            det_restart  <= 1'b0;
            adc_wake_en  <= 1'b0;
            adc_rate     <= RATE_LOW;
            det_rate     <= RATE_LOW;
        end else begin
            det_flag_clr <= 1'b0;
            det_restart  <= 1'b0;
            unique case (state)
                ST_PWRDN:    mod_pd       <= 1'b1;
                ST_DET_OFF:  det_en       <= 1'b0;
                ST_FLAG_CLR: det_flag_clr <= 1'b1;
                ST_DET_ON:   det_en       <= 1'b1;
                ST_DET_RST:  det_restart  <= 1'b1;
                ST_PATH: begin
                    unique case (cls)
                        CLS_DET: begin
                            det_en       <= 1'b1;
                            det_irq_mask <= 1'b0;
                            det_rate     <= cfg_det_rate;
                            mic_pd       <= 1'b0;
                            adc_pd       <= 1'b1;
                            adc_wake_en  <= 1'b1;
                        end
                        CLS_REC: begin
                            det_en       <= 1'b0;
                            det_irq_mask <= 1'b1;
                            adc_rate     <= cfg_adc_rate;
                            mic_pd       <= 1'b0;
                            adc_pd       <= 1'b0;
                            adc_wake_en  <= 1'b0;
                        end
                        CLS_OFF: begin
                            det_en       <= 1'b0;
                            det_irq_mask <= 1'b1;
                            mic_pd       <= 1'b1;
                            adc_pd       <= 1'b1;
                            adc_wake_en  <= 1'b0;
                        end
                        CLS_BAD: begin
                            det_rate     <= RATE_LOW;
                            adc_rate     <= RATE_LOW;
                            det_en       <= 1'b0;
                            det_irq_mask <= 1'b1;
                            mic_pd       <= 1'b1;
                            adc_pd       <= 1'b1;
                            adc_wake_en  <= 1'b0;
                        end
                        default: ;
                    endcase
                end
                ST_FINAL: mod_pd <= (cls == CLS_OFF) || (cls == CLS_BAD);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/afe_gain_bank.sv
module afe_gain_bank
    import afe_seq_pkg::*;
#(
    parameter int GAIN_W     = 6,
    parameter int GAIN_LIMIT = 43,
    parameter int AGC_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic              cfg_couple,
    input  logic [GAIN_W-1:0] cfg_gain_l,
    input  logic [GAIN_W-1:0] cfg_gain_r,
    input  logic [AGC_W-1:0]  cfg_agc_min,
    input  logic [AGC_W-1:0]  cfg_agc_max,
    output logic [GAIN_W-1:0] gain_l,
    output logic [GAIN_W-1:0] gain_r,
    output logic              gain_couple,
    output logic [AGC_W-1:0]  agc_min,
    output logic [AGC_W-1:0]  agc_max,
    output logic              cfg_err
);

    localparam int                NCH = 2;
    localparam logic [GAIN_W-1:0] LIM = GAIN_W'(GAIN_LIMIT);

    logic [GAIN_W-1:0] ch_gain [NCH];
    logic [NCH-1:0]    ch_over;
    logic              gain_bad;
    logic              agc_bad;

    assign ch_gain[0] = cfg_gain_l;
    assign ch_gain[1] = cfg_gain_r;

    // Per-channel range check
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        assign ch_over[ch] = (ch_gain[ch] > LIM);
    end

    assign gain_bad = |ch_over;
    assign agc_bad  = (cfg_agc_min > cfg_agc_max);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_l      <= '0;
            gain_r      <= '0;
            gain_couple <= 1'b0;
            agc_min     <= '0;
            agc_max     <= '0;
            cfg_err     <= 1'b0;
        end else begin
            unique case (state)
                ST_PWRDN: cfg_err <= 1'b0;
                ST_GAIN: begin
                    if (gain_bad) begin
                        cfg_err <= 1'b1;
                    end else begin
                        gain_couple <= cfg_couple;
                        gain_l      <= cfg_gain_l;
                        gain_r      <= cfg_couple ? cfg_gain_l : cfg_gain_r;
                    end
                end
                ST_AGC: begin
                    if (agc_bad) begin
                        cfg_err <= 1'b1;
                    end else begin
                        agc_min <= cfg_agc_min;
                        agc_max <= cfg_agc_max;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/afe_mode_seq.sv
module afe_mode_seq
    import afe_seq_pkg::*;
#(
    parameter int GAIN_W     = 6,
    parameter int GAIN_LIMIT = 43,
    parameter int AGC_W      = 5,
    parameter int RATE_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_mode,
    input  logic              cfg_couple,
    input  logic [GAIN_W-1:0] cfg_gain_l,
    input  logic [GAIN_W-1:0] cfg_gain_r,
    input  logic [AGC_W-1:0]  cfg_agc_min,
    input  logic [AGC_W-1:0]  cfg_agc_max,
    input  logic [RATE_W-1:0] cfg_adc_rate,
    input  logic [RATE_W-1:0] cfg_det_rate,
    output logic              mod_pd,
    output logic              mic_pd,
    output logic              adc_pd,
    output logic              det_en,
    output logic              det_irq_mask,
    output logic              det_flag_clr,
    output logic              det_restart,
    output logic              adc_wake_en,
    output logic [RATE_W-1:0] adc_rate,
    output logic [RATE_W-1:0] det_rate,
    output logic [GAIN_W-1:0] gain_l,
    output logic [GAIN_W-1:0] gain_r,
    output logic              gain_couple,
    output logic [AGC_W-1:0]  agc_min,
    output logic [AGC_W-1:0]  agc_max,
    output logic              busy,
    output logic              cfg_err
);

    seq_state_t        state;
    logic [MODE_W-1:0] cur_mode;

    afe_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_mode  (req_mode),
        .state     (state),
        .cur_mode  (cur_mode),
        .busy      (busy)
    );

    afe_path_regs #(.RATE_W(RATE_W)) u_path (
        .clk          (clk),
        .rst_n        (rst_n),
        .state        (state),
        .cur_mode     (cur_mode),
        .cfg_adc_rate (cfg_adc_rate),
        .cfg_det_rate (cfg_det_rate),
        .mod_pd       (mod_pd),
        .mic_pd       (mic_pd),
        .adc_pd       (adc_pd),
        .det_en       (det_en),
        .det_irq_mask (det_irq_mask),
        .det_flag_clr (det_flag_clr),
        .det_restart  (det_restart),
        .adc_wake_en  (adc_wake_en),
        .adc_rate     (adc_rate),
        .det_rate     (det_rate)
    );

    afe_gain_bank #(
        .GAIN_W     (GAIN_W),
        .GAIN_LIMIT (GAIN_LIMIT),
        .AGC_W      (AGC_W)
    ) u_gain (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .cfg_couple  (cfg_couple),
        .cfg_gain_l  (cfg_gain_l),
        .cfg_gain_r  (cfg_gain_r),
        .cfg_agc_min (cfg_agc_min),
        .cfg_agc_max (cfg_agc_max),
        .gain_l      (gain_l),
        .gain_r      (gain_r),
        .gain_couple (gain_couple),
        .agc_min     (agc_min),
        .agc_max     (agc_max),
        .cfg_err     (cfg_err)
    );

endmodule

// File: rtl/afe_mode_seq_chk.sv
module afe_mode_seq_chk #(
    parameter int GAIN_W     = 6,
    parameter int GAIN_LIMIT = 43,
    parameter int AGC_W      = 5,
    parameter int RATE_W     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mod_pd,
    input logic              mic_pd,
    input logic              adc_pd,
    input logic              det_en,
    input logic              det_irq_mask,
    input logic              det_flag_clr,
    input logic              det_restart,
    input logic              adc_wake_en,
    input logic [RATE_W-1:0] adc_rate,
    input logic [RATE_W-1:0] det_rate,
    input logic [GAIN_W-1:0] gain_l,
    input logic [GAIN_W-1:0] gain_r,
    input logic              gain_couple,
    input logic [AGC_W-1:0]  agc_min,
    input logic [AGC_W-1:0]  agc_max,
    input logic              cfg_err,
    input logic [2:0]        cur_mode
);

    logic [3:0] busy_cnt;
    logic       inactive;
    logic       is_rec;

    assign inactive = (cur_mode == 3'd0) || (cur_mode > 3'd4);
    assign is_rec   = (cur_mode >= 3'd2) && (cur_mode <= 3'd4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          busy_cnt <= '0;
        else if (!busy)      busy_cnt <= '0;
        else if (busy_cnt != 4'hF) busy_cnt <= busy_cnt + 4'd1;
    end

    p_pd_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> mod_pd);

    p_final_pd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (mod_pd == inactive));

    p_clr_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        det_flag_clr |-> !det_en);

    p_restart_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        det_restart |-> det_en);

    p_unmask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !det_irq_mask) |-> (det_en && adc_wake_en && !mic_pd));

    p_rec_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && is_rec) |-> (!mic_pd && !adc_pd && !det_en && det_irq_mask && !adc_wake_en));

    p_off_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && inactive) |-> (mic_pd && adc_pd && !det_en && det_irq_mask && !adc_wake_en));

    p_bad_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && (cur_mode > 3'd4)) |-> (adc_rate == '0 && det_rate == '0));

    p_gain_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_l <= GAIN_W'(GAIN_LIMIT)) && (gain_r <= GAIN_W'(GAIN_LIMIT)));

    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> ($stable(gain_l) && $stable(gain_r) && $stable(agc_min) && $stable(agc_max)));

    p_couple_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && gain_couple) |-> (gain_r == gain_l));

    p_agc_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        agc_min <= agc_max);

    p_busy_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < 4'd9));

endmodule

bind afe_mode_seq afe_mode_seq_chk #(
    .GAIN_W     (GAIN_W),
    .GAIN_LIMIT (GAIN_LIMIT),
    .AGC_W      (AGC_W),
    .RATE_W     (RATE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .mod_pd       (mod_pd),
    .mic_pd       (mic_pd),
    .adc_pd       (adc_pd),
    .det_en       (det_en),
    .det_irq_mask (det_irq_mask),
    .det_flag_clr (det_flag_clr),
    .det_restart  (det_restart),
    .adc_wake_en  (adc_wake_en),
    .adc_rate     (adc_rate),
    .det_rate     (det_rate),
    .gain_l       (gain_l),
    .gain_r       (gain_r),
    .gain_couple  (gain_couple),
    .agc_min      (agc_min),
    .agc_max      (agc_max),
    .cfg_err      (cfg_err),
    .cur_mode     (cur_mode)
);

// File: tb/afe_mode_seq_tb_top.sv
`timescale 1ns/1ps
module afe_mode_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [2:0] req_mode;
    logic       cfg_couple;
    logic [5:0] cfg_gain_l, cfg_gain_r;
    logic [4:0] cfg_agc_min, cfg_agc_max;
    logic [1:0] cfg_adc_rate, cfg_det_rate;
    logic       mod_pd, mic_pd, adc_pd, det_en, det_irq_mask;
    logic       det_flag_clr, det_restart, adc_wake_en;
    logic [1:0] adc_rate, det_rate;
    logic [5:0] gain_l, gain_r;
    logic       gain_couple;
    logic [4:0] agc_min, agc_max;
    logic       busy, cfg_err;

    always #4 clk = ~clk;

    afe_mode_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .cfg_couple(cfg_couple), .cfg_gain_l(cfg_gain_l), .cfg_gain_r(cfg_gain_r),
        .cfg_agc_min(cfg_agc_min), .cfg_agc_max(cfg_agc_max),
        .cfg_adc_rate(cfg_adc_rate), .cfg_det_rate(cfg_det_rate),
        .mod_pd(mod_pd), .mic_pd(mic_pd), .adc_pd(adc_pd), .det_en(det_en),
        .det_irq_mask(det_irq_mask), .det_flag_clr(det_flag_clr),
        .det_restart(det_restart), .adc_wake_en(adc_wake_en),
        .adc_rate(adc_rate), .det_rate(det_rate), .gain_l(gain_l), .gain_r(gain_r),
        .gain_couple(gain_couple), .agc_min(agc_min), .agc_max(agc_max),
        .busy(busy), .cfg_err(cfg_err)
    );

    typedef struct {
        string      tag;
        logic       mpd, micpd, adcpd, den, msk, wake, cp, err;
        logic [1:0] ar, dr;
        logic [5:0] gl, gr;
        logic [4:0] amin, amax;
        int         nclr, nrst, cyc;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    // Reference model state
    logic       m_mic = 1, m_adc = 1, m_den = 0, m_msk = 1, m_wake = 0, m_cp = 0;
    logic [1:0] m_ar = 0, m_dr = 0;
    logic [5:0] m_gl = 0, m_gr = 0;
    logic [4:0] m_amin = 0, m_amax = 0;

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic cp, input logic [5:0] gl, input logic [5:0] gr,
                           input logic [4:0] amin, input logic [4:0] amax,
                           input logic [1:0] ar, input logic [1:0] dr);
        @(negedge clk);
        cfg_couple = cp; cfg_gain_l = gl; cfg_gain_r = gr;
        cfg_agc_min = amin; cfg_agc_max = amax;
        cfg_adc_rate = ar; cfg_det_rate = dr;
    endtask

    // Driver side: push the expected outcome of a request
    task automatic predict(input logic [2:0] m, input string tag);
        exp_t e;
        bit is_det, is_rec, is_bad, gbad, abad;
        is_det = (m == 3'd1);
        is_rec = (m >= 3'd2) && (m <= 3'd4);
        is_bad = (m > 3'd4);
        if (is_det) begin
            m_mic = 0; m_adc = 1; m_den = 1; m_msk = 0; m_wake = 1; m_dr = cfg_det_rate;
        end else if (is_rec) begin
            m_mic = 0; m_adc = 0; m_den = 0; m_msk = 1; m_wake = 0; m_ar = cfg_adc_rate;
        end else begin
            m_mic = 1; m_adc = 1; m_den = 0; m_msk = 1; m_wake = 0;
            if (is_bad) begin m_ar = 0; m_dr = 0; end
        end
        gbad = (cfg_gain_l > 6'd43) || (cfg_gain_r > 6'd43);
        if (!gbad) begin
            m_gl = cfg_gain_l;
            m_gr = cfg_couple ? cfg_gain_l : cfg_gain_r;
            m_cp = cfg_couple;
        end
        abad = (cfg_agc_min > cfg_agc_max);
        if (!abad) begin m_amin = cfg_agc_min; m_amax = cfg_agc_max; end
        e.tag = tag;
        e.mpd = !(is_det || is_rec);
        e.micpd = m_mic; e.adcpd = m_adc; e.den = m_den; e.msk = m_msk; e.wake = m_wake;
        e.cp = m_cp; e.err = gbad || abad; e.ar = m_ar; e.dr = m_dr;
        e.gl = m_gl; e.gr = m_gr; e.amin = m_amin; e.amax = m_amax;
        e.nclr = is_det ? 1 : 0; e.nrst = is_det ? 1 : 0; e.cyc = is_det ? 9 : 5;
        q.push_back(e);
    endtask

    task automatic strobe(input logic [2:0] m);
        @(negedge clk);
        req_mode  = m;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n;
        n = 0;
        while ((q.size() != 0 || busy) && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(tag, "sequence completion", (q.size() == 0) ? 1 : 0, 1);
    endtask

    task automatic run(input logic [2:0] m, input string tag);
        predict(m, tag);
        strobe(m);
        wait_idle(tag);
    endtask

    // Monitor: gather per-sequence observations and compare on busy fall
    int   c_cyc = 0, c_clr = 0, c_rst = 0;
    bit   c_ord = 1, c_pd = 0, prev_busy = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            c_cyc = 0; c_clr = 0; c_rst = 0; c_ord = 1; c_pd = 0; prev_busy = 0;
        end else begin
            if (busy) begin
                c_cyc++;
                if (mod_pd) c_pd = 1;
                if (det_flag_clr) begin c_clr++; if (det_en) c_ord = 0; end
                if (det_restart) begin c_rst++; if (!det_en) c_ord = 0; end
            end
            if (prev_busy && !busy) begin
                if (q.size() == 0) begin
                    check("R11", "unexpected sequence", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.tag, "R1 powered down during sequence", c_pd, 1);
                    check(e.tag, "R2 mod_pd at end", mod_pd, e.mpd);
                    check(e.tag, "mic_pd", mic_pd, e.micpd);
                    check(e.tag, "adc_pd", adc_pd, e.adcpd);
                    check(e.tag, "det_en", det_en, e.den);
                    check(e.tag, "det_irq_mask", det_irq_mask, e.msk);
                    check(e.tag, "adc_wake_en", adc_wake_en, e.wake);
                    check(e.tag, "adc_rate", adc_rate, e.ar);
                    check(e.tag, "det_rate", det_rate, e.dr);
                    check(e.tag, "gain_l", gain_l, e.gl);
                    check(e.tag, "gain_r", gain_r, e.gr);
                    check(e.tag, "gain_couple", gain_couple, e.cp);
                    check(e.tag, "agc_min", agc_min, e.amin);
                    check(e.tag, "agc_max", agc_max, e.amax);
                    check(e.tag, "cfg_err", cfg_err, e.err);
                    check(e.tag, "R3 flag clear pulses", c_clr, e.nclr);
                    check(e.tag, "R3 restart pulses", c_rst, e.nrst);
                    check(e.tag, "R3 detector order", c_ord, 1);
                    check(e.tag, "R10 busy cycles", c_cyc, e.cyc);
                end
                c_cyc = 0; c_clr = 0; c_rst = 0; c_ord = 1; c_pd = 0;
            end
            prev_busy = busy;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(negedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; req_mode = 0;
        cfg_couple = 0; cfg_gain_l = 0; cfg_gain_r = 0;
        cfg_agc_min = 0; cfg_agc_max = 0; cfg_adc_rate = 0; cfg_det_rate = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        check("R12", "mod_pd", mod_pd, 1);
        check("R12", "mic_pd", mic_pd, 1);
        check("R12", "adc_pd", adc_pd, 1);
        check("R12", "det_irq_mask", det_irq_mask, 1);
        check("R12", "det_en", det_en, 0);
        check("R12", "adc_wake_en", adc_wake_en, 0);
        check("R12", "busy", busy, 0);
        check("R12", "cfg_err", cfg_err, 0);
        check("R12", "gains", {gain_l, gain_r}, 0);

        set_cfg(0, 6'd10, 6'd20, 5'd3, 5'd20, 2'd2, 2'd1);
        run(3'd2, "R4");                       // record to memory
        set_cfg(0, 6'd10, 6'd20, 5'd3, 5'd20, 2'd2, 2'd3);
        run(3'd1, "R3");                       // voice detect
        run(3'd0, "R5");                       // off keeps rates
        set_cfg(1, 6'd12, 6'd40, 5'd4, 5'd4, 2'd1, 2'd2);
        run(3'd3, "R8");                       // coupled, equal AGC limits (R9 boundary)
        set_cfg(0, 6'd43, 6'd43, 5'd4, 5'd9, 2'd3, 2'd2);
        run(3'd4, "R7");                       // gain 43 accepted
        set_cfg(0, 6'd44, 6'd5, 5'd1, 5'd2, 2'd1, 2'd1);
        run(3'd2, "R7");                       // gain 44 rejected, AGC still loaded
        set_cfg(0, 6'd7, 6'd8, 5'd9, 5'd8, 2'd0, 2'd1);
        run(3'd3, "R9");                       // inverted AGC rejected
        set_cfg(0, 6'd7, 6'd8, 5'd2, 5'd8, 2'd2, 2'd3);
        run(3'd1, "R3");
        run(3'd6, "R6");                       // unknown: rates forced low
        set_cfg(0, 6'd1, 6'd2, 5'd0, 5'd31, 2'd3, 2'd2);
        // R11: second strobe while the first sequence is busy
        predict(3'd1, "R11");
        strobe(3'd1);
        repeat (3) @(negedge clk);
        predict(3'd2, "R11");
        strobe(3'd2);
        wait_idle("R11");
        run(3'd7, "R6");
        run(3'd4, "R2");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule